// File: doc/BRIEF.md
# PHY Initialization Sync Sequencer

This block runs the start-up handshake of a storage-card I/O PHY. Software writes one 32-bit timing-control word. That word holds four 4-bit duration fields. Setting its top bit launches a pulse train on two synchronizer controls, and the train runs in this order:

1. A reset strobe.
2. A quiet gap.
3. An enable strobe.
4. A settling wait.
5. A fixed tail of eight cycles, which covers four card-bus clocks and four system-bus clocks.

All durations are counted in bus-clock cycles. The top bit reads back as 1 while the train runs and drops to 0 by itself when the train is done. Software polls that bit to learn that the PHY may be used.

The train must be launched again whenever one of these happens:

- the card clock frequency changes;
- the card clock is stopped and restarted;
- the timing or function configuration changes.

Two mode bits in the same word mark the slow bypass mode and the SDIO mode. They are ordinary read/write storage and do not affect the train.

Top module: `phy_init_seq`

## Requirements
- R1: After reset, `cfg_rdata` reads 0x0000_0000, and both `sync_rst_o` and `sync_en_o` are low.
- R2: A write with bit 31 set while idle starts a train. Bit 31 reads 1 from the next cycle for exactly RST+GAP+EN+WAIT+8 cycles, then reads 0. The fields are RST = bits [3:0], GAP = bits [7:4], EN = bits [11:8] and WAIT = bits [15:12]. The same write also loads these fields.
- R3: `sync_rst_o` is high for exactly RST cycles, starting at the first busy cycle.
- R4: `sync_en_o` stays low for GAP cycles after the reset strobe ends. It is then high for exactly EN cycles, and stays low for the rest of the train.
- R5: A field value of 0 gives a phase of zero cycles. With all fields 0 the train is exactly 8 busy cycles, and neither strobe rises.
- R6: A write while busy leaves bits [15:0] unchanged.
- R7: A write with bit 31 set while busy neither restarts nor lengthens the running train.
- R8: Bit 29 (slow bypass) and bit 28 (SDIO mode) can be written and read back at any time, and they do not change the train. Bit 30 and bits [27:16] read as 0.
- R9: The two strobes are never high together, and both are low whenever bit 31 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the timing-control word |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Current timing-control word, including the busy bit |
| sync_rst_o | output | 1 | Synchronizer reset strobe |
| sync_en_o | output | 1 | Synchronizer enable strobe |

## Verification
The hardest case to reach from the ports is a second write that lands in the middle of a running train, carrying new fields and a new start bit. The stimulus starts a train, counts two falling edges, and then issues that write. It then checks two things: the strobe and busy trace stays the one predicted for the original fields, and the fields read back unchanged. Trains with every field at 0 and every field at 15 cover the shortest and longest cases.

// File: rtl/phy_init_seq.sv
module phy_init_seq #(
  parameter int FLD_W = 4,
  parameter int TAIL  = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  output logic        sync_rst_o,
  output logic        sync_en_o
);
  localparam int NFLD  = 4;
  localparam int FBITS = NFLD * FLD_W;
  localparam int PADW  = 28 - FBITS;
  localparam int MAXT  = NFLD * ((1 << FLD_W) - 1) + TAIL;
  localparam int CNT_W = $clog2(MAXT + 1);

  logic [NFLD-1:0][FLD_W-1:0] len_q;
  logic                       busy_q, slow_q, sdio_q;
  logic [CNT_W-1:0]           cnt_q;
  logic [CNT_W-1:0]           rst_end, gap_end, en_end, last;

  assign rst_end = CNT_W'(len_q[0]);
  assign gap_end = rst_end + CNT_W'(len_q[1]);
  assign en_end  = gap_end + CNT_W'(len_q[2]);
  assign last    = en_end + CNT_W'(len_q[3]) + CNT_W'(TAIL - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q  <= '0;
      busy_q <= 1'b0;
      slow_q <= 1'b0;
      sdio_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (cfg_we) begin
        slow_q <= cfg_wdata[29];
        sdio_q <= cfg_wdata[28];
      end
      if (cfg_we && !busy_q) begin
        len_q  <= cfg_wdata[FBITS-1:0];
        busy_q <= cfg_wdata[31];
        cnt_q  <= '0;
      end else if (busy_q) begin
        if (cnt_q == last) begin
          busy_q <= 1'b0;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign sync_rst_o = busy_q && (cnt_q < rst_end);
  assign sync_en_o  = busy_q && (cnt_q >= gap_end) && (cnt_q < en_end);
  assign cfg_rdata  = {busy_q, 1'b0, slow_q, sdio_q, {PADW{1'b0}}, len_q};
endmodule

module phy_init_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic [31:0] cfg_wdata,
  input logic [31:0] cfg_rdata,
  input logic        sync_rst_o,
  input logic        sync_en_o
);
  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(sync_rst_o && sync_en_o));
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rdata[31] |-> (!sync_rst_o && !sync_en_o));
  a_r2_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_rdata[31] && cfg_we && cfg_wdata[31]) |=> cfg_rdata[31]);
  a_r6_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[31] |=> $stable(cfg_rdata[15:0]));
  a_r3_rst_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_rdata[31]) |-> (sync_rst_o == (cfg_rdata[3:0] != 4'd0)));
  a_r8_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[30] == 1'b0) && (cfg_rdata[27:16] == 12'd0));
endmodule

bind phy_init_seq phy_init_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata), .sync_rst_o(sync_rst_o), .sync_en_o(sync_en_o)
);

// File: tb/phy_init_seq_tb.sv
module phy_init_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        sync_rst_o, sync_en_o;

  int nchk = 0;
  int nbad = 0;
  logic [2:0] expq [$];
  logic m29 = 1'b0;
  logic m28 = 1'b0;

  always #5 clk = ~clk;

  phy_init_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .sync_rst_o(sync_rst_o), .sync_en_o(sync_en_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops one expected {busy,rst,en} per cycle (R2 R3 R4 R5 R9)
  always @(negedge clk) begin
    if (expq.size() > 0) begin
      logic [2:0] e;
      e = expq.pop_front();
      chk("R2/R3/R4 trace", {29'd0, cfg_rdata[31], sync_rst_o, sync_en_o}, {29'd0, e});
    end
  end

  task automatic run(input logic [3:0] r, g, e, w, input bit disturb);
    logic [31:0] d;
    int t;
    d = {1'b1, 1'b0, m29, m28, 12'd0, w, e, g, r};
    t = r + g + e + w + 8;
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = d;
    @(posedge clk); #1 cfg_we = 1'b0;
    for (int i = 0; i < t; i++)
      expq.push_back({1'b1, i < r, (i >= r + g) && (i < r + g + e)});
    expq.push_back(3'b000);
    if (disturb) begin
      // R6 R7: mid-train write of new fields plus start
      repeat (2) @(negedge clk);
      cfg_we = 1'b1;
      cfg_wdata = {1'b1, 1'b0, m29, m28, 12'd0, ~d[15:0]};
      @(posedge clk); #1 cfg_we = 1'b0;
    end
    wait (expq.size() == 0);
    @(negedge clk);
    chk("R6 fields kept", {16'd0, cfg_rdata[15:0]}, {16'd0, d[15:0]});
    chk("R8 modes kept", {30'd0, cfg_rdata[29:28]}, {30'd0, m29, m28});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset rdata", cfg_rdata, 32'h0);
    chk("R1 reset strobes", {30'd0, sync_rst_o, sync_en_o}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", cfg_rdata, 32'h0);

    run(4'd1, 4'd2, 4'd3, 4'd4, 1'b0);   // R2 R3 R4
    run(4'd0, 4'd0, 4'd0, 4'd0, 1'b0);   // R5 shortest
    run(4'd15, 4'd15, 4'd15, 4'd15, 1'b0); // R2 longest
    run(4'd3, 4'd0, 4'd2, 4'd0, 1'b0);   // R4 zero gap
    run(4'd0, 4'd5, 4'd0, 4'd1, 1'b0);   // R5 no strobes
    run(4'd4, 4'd3, 4'd2, 4'd1, 1'b1);   // R6 R7

    // R8: mode bits and zero bits, no start
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = 32'h7FFF_FFFF;
    @(negedge clk);
    cfg_we = 1'b0;
    chk("R8 readback", cfg_rdata, 32'h3000_FFFF);
    m29 = 1'b1; m28 = 1'b1;
    run(4'd2, 4'd1, 4'd2, 4'd0, 1'b0);   // R8 modes do not alter train
    m29 = 1'b0; m28 = 1'b1;
    run(4'd1, 4'd1, 4'd1, 4'd1, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule